// File: doc/BRIEF.md
# Re-entrant SMM Entry Controller

This block decides when a core enters and leaves system management mode when management interrupts can nest. It watches two request sources: an internal event line and an external request line. It also accepts a software write port for a nest-enable bit and a resume strobe that marks the return from a handler. It keeps a level counter, the nest-enable bit and a nested-status bit. Each entry pushes the nested-status value held before that entry onto a small last-in-first-out header store, and each resume pops that value back.

External requests that cannot be served are held in a single pending flag and are not lost. Internal events raised while already inside the mode are dropped. When both sources ask in the same cycle, the internal one goes first. Every entry produces a one-cycle taken pulse, qualified by a flag that tells which source was served. All state is synchronous to one clock and is returned to the outside-mode state by an active-low synchronous reset.

Top module: `smi_nest_ctrl`

## Requirements
- R1: After reset and whenever the level is 0, `nest_en` reads 1, `nested` reads 0 and `smi_taken` reads 0.
- R2: When a request is taken, the registered outputs at the next clock edge show `smi_taken`=1, `nest_en`=0, `nested`=1 and the level raised by one.
- R3: A resume strobe while the level is above 0 lowers the level by one at the next edge and sets `nest_en` to 1. It restores `nested` to the value saved at that entry: 0 when the level returns to 0, and 1 otherwise.
- R4: While in SMM with `nest_en`=0, an external request is held pending. It is taken one cycle after `nest_en` is written to 1, or one cycle after the resume that brings the level to 0.
- R5: While in SMM with `nest_en`=1 and the level below DEPTH, an external request is taken at the next edge as a deeper level.
- R6: An internal request made while the level is above 0 is dropped. It produces no taken pulse, either at that time or after the mode is left.
- R7: When internal and external requests arrive in the same cycle at level 0, the internal one is taken (`smi_src_int`=1). The external one stays pending and is taken later with `smi_src_int`=0.
- R8: At level DEPTH with `nest_en`=1, an external request stays pending and `hdr_ovf` reads 1 while the request is blocked. The request is taken after a resume frees a slot.
- R9: A resume strobe at level 0 is ignored (the level stays 0) and `rsm_err` pulses high for exactly one cycle.
- R10: Software writes to `nest_en` take effect only inside SMM. At level 0 a write of 0 is ignored.
- R11: `smi_taken` is a single-cycle pulse for each entry. `smi_src_int` is 1 for an internal entry and 0 for an external one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 1 | External SMI request, one-cycle strobe |
| int_req | input | 1 | Internal SMI event, one-cycle strobe |
| nest_wr | input | 1 | Software write strobe for nest-enable |
| nest_wr_val | input | 1 | Value written to nest-enable |
| rsm | input | 1 | Resume strobe from the handler |
| smi_taken | output | 1 | One-cycle pulse on each SMM entry |
| smi_src_int | output | 1 | Source of the entry: 1 internal, 0 external |
| smm_level | output | LVL_W | Current nesting level |
| nest_en | output | 1 | Nest-enable bit |
| nested | output | 1 | Nested-status bit |
| hdr_ovf | output | 1 | External request blocked by a full header store |
| rsm_err | output | 1 | One-cycle pulse on a resume at level 0 |

## Verification
The bench holds an external request across a masked period and then releases it by two routes: a software enable, and a resume to level 0. A controller that drops the held request never pulses again, and one that ignores the mask enters too early. It fires both sources in the same cycle to catch a design that serves the external source first or loses the loser. It fills the header store to its depth and checks that a design with a wrong bound either wraps the level or silently discards the request instead of flagging it. It also sends internal events while inside the mode, stray resumes, and writes at level 0, where a faulty design would enter, underflow the level or clear the enable outside the mode.

// File: rtl/smi_nest_pkg.sv
package smi_nest_pkg;

    localparam int unsigned HDR_DEPTH = 4;
    localparam int unsigned LVL_W     = $clog2(HDR_DEPTH + 1);

    typedef logic [LVL_W-1:0] level_t;

    typedef struct packed {
        level_t level;
        logic   nest_en;
        logic   nested;
        logic   ext_pend;
        logic   taken;
        logic   src_int;
        logic   ovf;
        logic   rsm_err;
    } ctrl_state_t;

endpackage

// File: rtl/smi_hdr_stack.sv
module smi_hdr_stack #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             push_bit,
    input  logic [LVL_W-1:0] level,
    output logic             top_bit
);
    logic [DEPTH-1:0] slot_q;

    // Entry g holds the status saved when the level went from g to g+1.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= 1'b0;
            else if (push && (level == LVL_W'(g)))
                slot_q[g] <= push_bit;
        end
    end

    // Value saved at the entry of the current level.
    always_comb begin
        top_bit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (level == LVL_W'(i + 1))
                top_bit = slot_q[i];
        end
    end
endmodule

// File: rtl/smi_take_arb.sv
module smi_take_arb (
    input  logic int_req,
    input  logic ext_any,
    input  logic lvl_zero,
    input  logic nest_en,
    input  logic room,
    input  logic rsm_busy,
    output logic take_int,
    output logic take_ext,
    output logic blocked_full
);
    logic ext_gate;

    always_comb begin
        // Internal events only count outside SMM; they win over external.
        take_int     = int_req && lvl_zero && !rsm_busy;
        ext_gate     = lvl_zero || (nest_en && room);
        take_ext     = ext_any && !take_int && !rsm_busy && ext_gate;
        blocked_full = ext_any && !rsm_busy && !lvl_zero && nest_en && !room;
    end
endmodule

// File: rtl/smi_nest_ctrl.sv
module smi_nest_ctrl
    import smi_nest_pkg::*;
#(
    parameter int unsigned DEPTH = HDR_DEPTH,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_req,
    input  logic          int_req,
    input  logic          nest_wr,
    input  logic          nest_wr_val,
    input  logic          rsm,
    output logic          smi_taken,
    output logic          smi_src_int,
    output logic [LW-1:0] smm_level,
    output logic          nest_en,
    output logic          nested,
    output logic          hdr_ovf,
    output logic          rsm_err
);
    typedef struct packed {
        logic [LW-1:0] level;
        logic          nest_en;
        logic          nested;
        logic          ext_pend;
        logic          taken;
        logic          src_int;
        logic          ovf;
        logic          rsm_err;
    } st_t;

    localparam st_t ST_RESET = '{level: '0, nest_en: 1'b1, nested: 1'b0,
                                 ext_pend: 1'b0, taken: 1'b0, src_int: 1'b0,
                                 ovf: 1'b0, rsm_err: 1'b0};

    st_t  st_d, st_q;
    logic lvl_zero, room, rsm_ok, rsm_busy, ext_any;
    logic take_int, take_ext, take, blocked_full, saved_bit;

    assign lvl_zero = (st_q.level == '0);
    assign room     = (st_q.level < LW'(DEPTH));
    assign rsm_ok   = rsm && !lvl_zero;
    assign rsm_busy = rsm_ok;
    assign ext_any  = ext_req || st_q.ext_pend;
    assign take     = take_int || take_ext;

    smi_take_arb u_arb (
        .int_req     (int_req),
        .ext_any     (ext_any),
        .lvl_zero    (lvl_zero),
        .nest_en     (st_q.nest_en),
        .room        (room),
        .rsm_busy    (rsm_busy),
        .take_int    (take_int),
        .take_ext    (take_ext),
        .blocked_full(blocked_full)
    );

    smi_hdr_stack #(.DEPTH(DEPTH), .LVL_W(LW)) u_hdr (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (take),
        .push_bit(st_q.nested),
        .level   (st_q.level),
        .top_bit (saved_bit)
    );

    always_comb begin
        st_d          = st_q;
        st_d.taken    = take;
        st_d.src_int  = take ? take_int : st_q.src_int;
        st_d.ovf      = blocked_full;
        st_d.rsm_err  = rsm && lvl_zero;
        st_d.ext_pend = ext_any && !take_ext;

        if (take) begin
            st_d.level   = st_q.level + LW'(1);
            st_d.nest_en = 1'b0;
            st_d.nested  = 1'b1;
        end else if (rsm_ok) begin
            st_d.level   = st_q.level - LW'(1);
            st_d.nest_en = 1'b1;
            st_d.nested  = saved_bit;
        end else if (nest_wr && !lvl_zero) begin
            st_d.nest_en = nest_wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_RESET;
        else
            st_q <= st_d;
    end

    assign smi_taken   = st_q.taken;
    assign smi_src_int = st_q.src_int;
    assign smm_level   = st_q.level;
    assign nest_en     = st_q.nest_en;
    assign nested      = st_q.nested;
    assign hdr_ovf     = st_q.ovf;
    assign rsm_err     = st_q.rsm_err;
endmodule

// File: rtl/smi_nest_ctrl_chk.sv
module smi_nest_ctrl_chk #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned LW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rsm,
    input logic          smi_taken,
    input logic [LW-1:0] smm_level,
    input logic          nest_en,
    input logic          nested,
    input logic          rsm_err
);
    a_r1_idle_state: assert property (@(posedge clk) disable iff (!rst_n)
        (smm_level == '0) |-> (nest_en && !nested && !smi_taken));

    a_r2_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
        smi_taken |-> (!nest_en && nested && smm_level != '0));

    a_r3_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (rsm && smm_level != '0) |=> (nest_en && !smi_taken
                                      && smm_level == $past(smm_level) - LW'(1)));

    a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        smm_level <= LW'(DEPTH));

    a_r9_stray_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (rsm && smm_level == '0) |=> (rsm_err && smm_level == '0));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        smi_taken |=> !smi_taken || (smm_level != $past(smm_level)));
endmodule

bind smi_nest_ctrl smi_nest_ctrl_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rsm      (rsm),
    .smi_taken(smi_taken),
    .smm_level(smm_level),
    .nest_en  (nest_en),
    .nested   (nested),
    .rsm_err  (rsm_err)
);

// File: tb/smi_nest_ctrl_bench.sv
module smi_nest_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic ext_req = 0, int_req = 0, nest_wr = 0, nest_wr_val = 0, rsm = 0;
    logic smi_taken, smi_src_int, nest_en, nested, hdr_ovf, rsm_err;
    logic [LW-1:0] smm_level;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smi_nest_ctrl #(.DEPTH(DEPTH)) u_smi_nest_ctrl (.*);

    task automatic tick();
        @(posedge clk); #1;
        ext_req = 0; int_req = 0; nest_wr = 0; rsm = 0;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_rsm(); rsm = 1; tick(); endtask
    task automatic set_nest(bit v); nest_wr = 1; nest_wr_val = v; tick(); endtask

    task automatic t_reset();
        chk("R1", "level", smm_level, 0); chk("R1", "nest_en", nest_en, 1);
        chk("R1", "nested", nested, 0);   chk("R1", "taken", smi_taken, 0);
    endtask

    task automatic t_single();
        ext_req = 1; tick();
        chk("R2", "taken", smi_taken, 1); chk("R11", "src", smi_src_int, 0);
        chk("R2", "level", smm_level, 1); chk("R2", "nest_en", nest_en, 0);
        chk("R2", "nested", nested, 1);
        tick(); chk("R11", "pulse width", smi_taken, 0);
        do_rsm();
        chk("R3", "level", smm_level, 0); chk("R3", "nest_en", nest_en, 1);
        chk("R3", "nested", nested, 0);
    endtask

    task automatic t_nested();
        ext_req = 1; tick(); set_nest(1);
        ext_req = 1; tick();
        chk("R5", "taken", smi_taken, 1); chk("R5", "level", smm_level, 2);
        do_rsm();
        chk("R3", "level after inner", smm_level, 1);
        chk("R3", "nested restored 1", nested, 1); chk("R3", "nest_en", nest_en, 1);
        set_nest(0); do_rsm();
        chk("R3", "nested restored 0", nested, 0);
    endtask

    task automatic t_hold();
        ext_req = 1; tick();
        ext_req = 1; tick(); chk("R4", "masked held", smi_taken, 0);
        set_nest(1); chk("R4", "no take on write edge", smi_taken, 0);
        tick(); chk("R4", "taken after enable", smi_taken, 1);
        chk("R4", "level", smm_level, 2);
        do_rsm(); set_nest(0);
        ext_req = 1; tick(); chk("R4", "held at level1", smi_taken, 0);
        do_rsm(); chk("R4", "level0 after rsm", smm_level, 0);
        tick(); chk("R4", "taken after exit", smi_taken, 1);
        chk("R4", "level", smm_level, 1);
        do_rsm();
    endtask

    task automatic t_int_in_smm();
        ext_req = 1; tick(); set_nest(1);
        int_req = 1; tick(); chk("R6", "int in smm", smi_taken, 0);
        tick(); chk("R6", "level", smm_level, 1);
        do_rsm(); tick();
        chk("R6", "no late take", smi_taken, 0); chk("R6", "level0", smm_level, 0);
    endtask

    task automatic t_simul();
        int_req = 1; ext_req = 1; tick();
        chk("R7", "taken", smi_taken, 1); chk("R7", "src int", smi_src_int, 1);
        tick(); chk("R7", "ext held", smi_taken, 0);
        set_nest(1); tick();
        chk("R7", "ext taken", smi_taken, 1); chk("R7", "src ext", smi_src_int, 0);
        chk("R7", "level", smm_level, 2);
        do_rsm(); do_rsm();
    endtask

    task automatic t_depth();
        for (int i = 0; i < DEPTH; i++) begin
            if (i != 0) set_nest(1);
            ext_req = 1; tick();
        end
        chk("R8", "full level", smm_level, DEPTH);
        set_nest(1);
        ext_req = 1; tick();
        chk("R8", "no take full", smi_taken, 0); chk("R8", "ovf", hdr_ovf, 1);
        chk("R8", "level kept", smm_level, DEPTH);
        do_rsm(); chk("R8", "level after rsm", smm_level, DEPTH - 1);
        tick(); chk("R8", "taken after room", smi_taken, 1);
        chk("R8", "level", smm_level, DEPTH); chk("R8", "ovf clear", hdr_ovf, 0);
        for (int i = 0; i < DEPTH; i++) do_rsm();
        chk("R8", "unwound", smm_level, 0); chk("R8", "nested", nested, 0);
    endtask

    task automatic t_stray();
        do_rsm();
        chk("R9", "err", rsm_err, 1); chk("R9", "level", smm_level, 0);
        tick(); chk("R9", "err one cycle", rsm_err, 0);
    endtask

    task automatic t_wr_idle();
        set_nest(0); chk("R10", "idle write ignored", nest_en, 1);
        ext_req = 1; tick(); set_nest(1);
        chk("R10", "write in smm", nest_en, 1);
        do_rsm();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        t_reset(); t_single(); t_nested(); t_hold(); t_int_in_smm();
        t_simul(); t_depth(); t_stray(); t_wr_idle();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule